// File: doc/BRIEF.md
# Calibrated One-Second Divider

This block turns a 32,768 Hz oscillator enable into a one-second tick and trims the rate in software-chosen steps. Division runs in two stages: a prescaler that makes one pulse per 128 enables, and a second stage that counts those pulses up to one second. Rate correction acts on the pulses of the second stage.

A 5-bit magnitude and a sign bit choose the correction. Corrections repeat over a frame of 64 minutes. With magnitude n, the first second of each of the first 2n minutes of the frame is stretched or shortened, and no other second changes. With the sign clear, one stage pulse is swallowed, so the second lasts 128 extra enables and the clock runs slower. With the sign set, two extra stage pulses are counted, so the second ends 256 enables early and the clock runs faster.

A halt input stops the count so the oscillator can be parked. The block exposes the position in the 64-minute frame so that a frame position can be read or checked.

Top module: `osc_cal_divider`

## Requirements
- R1: While reset is held (synchronous, active low), sec_tick is 0 and minute_idx is 0. Both are 0 after the first clock edge with reset low.
- R2: With cal_mag = 0, every second lasts exactly PRE_DIV*SUB_STEPS accepted osc_en pulses (32,768 at default parameters), whatever the value of cal_pos.
- R3: For an adjusted second with cal_pos = 0, the second lasts PRE_DIV*(SUB_STEPS+1) accepted enables (32,896 at default parameters).
- R4: For an adjusted second with cal_pos = 1, the second lasts PRE_DIV*(SUB_STEPS-2) accepted enables (32,512 at default parameters).
- R5: A second is adjusted only if it is second 0 of its minute, minute_idx < 2*cal_mag, and cal_mag is not 0. All other seconds last PRE_DIV*SUB_STEPS enables.
- R6: minute_idx counts minutes from 0 to MIN_PER_CYCLE-1 and wraps to 0. It advances only in the cycle in which the tick that ends second SEC_PER_MIN-1 of a minute appears.
- R7: While halt is 1, no tick appears and minute_idx holds. The enables already counted in the current second are dropped, so the first second after halt falls takes a full second's worth of enables.
- R8: sec_tick is a single-cycle pulse. It is high in the cycle after the clock edge that accepts the enable completing the second.
- R9: Only cycles with osc_en = 1 advance the count. Gaps in osc_en stretch a second in clock cycles but not in accepted enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| osc_en | input | 1 | One pulse per oscillator period (nominally 32,768 per second) |
| halt | input | 1 | Stops counting and discards the partial second |
| cal_mag | input | MAG_W | Correction magnitude, 0 to 31 |
| cal_pos | input | 1 | 1 = speed up (shorten seconds), 0 = slow down (lengthen seconds) |
| sec_tick | output | 1 | One-cycle pulse at the end of each second |
| minute_idx | output | MIN_W | Minute position within the correction frame |

## Verification
The bench targets the edges of the correction window. It uses magnitude 1, where only minutes 0 and 1 are touched, and magnitude 31, where minute 61 is the last adjusted minute and minute 62 is not. A window test that is off by one would stretch or shorten the wrong minute. The bench also checks that the frame wraps back from its last minute and corrects minute 0 again, and that a nonzero sign alone has no effect when the magnitude is 0. It halts in the middle of a second: a design that kept the partial count would tick early after release. The bench also runs a sparse enable pattern, which catches a design that counts clock cycles instead of enables.

// File: rtl/osc_cal_pkg.sv
// Shared types for the calibrated one-second divider.
package osc_cal_pkg;
    // Per-second correction chosen by the frame counter.
    typedef enum logic [1:0] {
        ADJ_NONE  = 2'd0,   // nominal second
        ADJ_BLANK = 2'd1,   // swallow one stage pulse (slower clock)
        ADJ_SPLIT = 2'd2    // count two extra stage pulses (faster clock)
    } adj_e;
endpackage

// File: rtl/cal_prescaler.sv
// First divide stage: emits one stage pulse per PRE_DIV accepted enables.
// Assumes PRE_DIV >= 2. A clear discards the partial count.
module cal_prescaler #(
    parameter int PRE_DIV = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic osc_en,
    output logic stage_pulse
);
    localparam int W = $clog2(PRE_DIV);
    localparam logic [W-1:0] LAST = W'(PRE_DIV - 1);

    logic [W-1:0] cnt_q;

    // Pulse on the enable that completes a group of PRE_DIV.
    assign stage_pulse = osc_en && !clear && (cnt_q == LAST);

    // Count accepted enables modulo PRE_DIV.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= '0;
        end else if (osc_en) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/cal_sub_divider.sv
// Second divide stage: counts stage pulses up to one second. The pulse count
// per second is SUB_STEPS, one more when blanking, two fewer when splitting.
// Assumes SUB_STEPS >= 4. sec_done is combinational; sec_tick is registered.
module cal_sub_divider
    import osc_cal_pkg::*;
#(
    parameter int SUB_STEPS = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic stage_pulse,
    input  adj_e adj_mode,
    output logic sec_done,
    output logic sec_tick
);
    localparam int W = $clog2(SUB_STEPS + 2);
    localparam logic [W-1:0] LAST_NONE  = W'(SUB_STEPS - 1);
    localparam logic [W-1:0] LAST_BLANK = W'(SUB_STEPS);
    localparam logic [W-1:0] LAST_SPLIT = W'(SUB_STEPS - 3);

    logic [W-1:0] cnt_q;
    logic [W-1:0] last_idx;

    // Choose the final pulse index of the current second.
    always_comb begin
        case (adj_mode)
            ADJ_BLANK: last_idx = LAST_BLANK;
            ADJ_SPLIT: last_idx = LAST_SPLIT;
            default:   last_idx = LAST_NONE;
        endcase
    end

    assign sec_done = stage_pulse && (cnt_q >= last_idx);

    // Count stage pulses within the current second.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= '0;
        end else if (stage_pulse) begin
            cnt_q <= sec_done ? '0 : cnt_q + 1'b1;
        end
    end

    // Register the end-of-second strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_tick <= 1'b0;
        end else begin
            sec_tick <= sec_done;
        end
    end
endmodule

// File: rtl/cal_frame_counter.sv
// Tracks the second within the minute and the minute within the correction
// frame, and decides whether the running second is adjusted. It advances only
// on sec_done, so a halt in the dividers also freezes it.
module cal_frame_counter
    import osc_cal_pkg::*;
#(
    parameter int SEC_PER_MIN   = 60,
    parameter int MIN_PER_CYCLE = 64,
    parameter int MAG_W         = 5,
    localparam int MIN_W        = $clog2(MIN_PER_CYCLE)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sec_done,
    input  logic [MAG_W-1:0] cal_mag,
    input  logic             cal_pos,
    output logic [MIN_W-1:0] minute_idx,
    output adj_e             adj_mode
);
    localparam int SW = $clog2(SEC_PER_MIN);
    localparam int CW = ((MIN_W > MAG_W + 1) ? MIN_W : MAG_W + 1) + 1;
    localparam logic [SW-1:0]    SEC_LAST = SW'(SEC_PER_MIN - 1);
    localparam logic [MIN_W-1:0] MIN_LAST = MIN_W'(MIN_PER_CYCLE - 1);

    logic [SW-1:0]    sec_q;
    logic [MIN_W-1:0] min_q;
    logic             in_window;

    // Advance second and minute positions at each completed second.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_q <= '0;
            min_q <= '0;
        end else if (sec_done) begin
            if (sec_q == SEC_LAST) begin
                sec_q <= '0;
                min_q <= (min_q == MIN_LAST) ? '0 : min_q + 1'b1;
            end else begin
                sec_q <= sec_q + 1'b1;
            end
        end
    end

    // Adjust second 0 of minutes below twice the magnitude.
    assign in_window = (sec_q == '0) && (cal_mag != '0)
                    && (CW'(min_q) < CW'({cal_mag, 1'b0}));

    // Map window and sign onto the correction kind.
    always_comb begin
        if (!in_window)   adj_mode = ADJ_NONE;
        else if (cal_pos) adj_mode = ADJ_SPLIT;
        else              adj_mode = ADJ_BLANK;
    end

    assign minute_idx = min_q;
endmodule

// File: rtl/osc_cal_divider.sv
// Top: oscillator enable to one-second tick with sign-magnitude rate trim
// spread over a frame of MIN_PER_CYCLE minutes. Halt clears the partial
// second and freezes the frame position.
module osc_cal_divider
    import osc_cal_pkg::*;
#(
    parameter int PRE_DIV       = 128,
    parameter int SUB_STEPS     = 256,
    parameter int SEC_PER_MIN   = 60,
    parameter int MIN_PER_CYCLE = 64,
    parameter int MAG_W         = 5,
    localparam int MIN_W        = $clog2(MIN_PER_CYCLE)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             osc_en,
    input  logic             halt,
    input  logic [MAG_W-1:0] cal_mag,
    input  logic             cal_pos,
    output logic             sec_tick,
    output logic [MIN_W-1:0] minute_idx
);
    logic stage_pulse;
    logic sec_done;
    adj_e adj_mode;

    cal_prescaler #(.PRE_DIV(PRE_DIV)) u_pre (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (halt),
        .osc_en      (osc_en),
        .stage_pulse (stage_pulse)
    );

    cal_sub_divider #(.SUB_STEPS(SUB_STEPS)) u_sub (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (halt),
        .stage_pulse (stage_pulse),
        .adj_mode    (adj_mode),
        .sec_done    (sec_done),
        .sec_tick    (sec_tick)
    );

    cal_frame_counter #(
        .SEC_PER_MIN   (SEC_PER_MIN),
        .MIN_PER_CYCLE (MIN_PER_CYCLE),
        .MAG_W         (MAG_W)
    ) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .sec_done   (sec_done),
        .cal_mag    (cal_mag),
        .cal_pos    (cal_pos),
        .minute_idx (minute_idx),
        .adj_mode   (adj_mode)
    );
endmodule

// File: rtl/osc_cal_divider_chk.sv
// Port-level properties of the calibrated divider, bound to every instance.
module osc_cal_divider_chk #(
    parameter int MIN_PER_CYCLE = 64,
    parameter int MIN_W         = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             osc_en,
    input logic             halt,
    input logic             sec_tick,
    input logic [MIN_W-1:0] minute_idx
);
    // R7
    halt_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> !sec_tick);

    // R7
    halt_hold_minute_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> $stable(minute_idx));

    // R6
    minute_only_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(minute_idx) |-> sec_tick);

    // R6
    minute_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && !$stable(minute_idx)) |->
        (int'(minute_idx) == (int'($past(minute_idx)) + 1) % MIN_PER_CYCLE));

    // R8
    tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick |=> !sec_tick);

    // R9
    tick_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick |-> $past(osc_en));
endmodule

bind osc_cal_divider osc_cal_divider_chk #(
    .MIN_PER_CYCLE (MIN_PER_CYCLE),
    .MIN_W         (MIN_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .osc_en     (osc_en),
    .halt       (halt),
    .sec_tick   (sec_tick),
    .minute_idx (minute_idx)
);

// File: tb/osc_cal_divider_bench.sv
module osc_cal_divider_bench;
    localparam int PRE = 4;
    localparam int SUB = 8;
    localparam int SPM = 3;
    localparam int MPC = 64;
    localparam int NOM = PRE * SUB;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       osc_en = 1'b0;
    logic       halt;
    logic [4:0] cal_mag;
    logic       cal_pos;
    logic       sec_tick;
    logic [5:0] minute_idx;
    logic       full_tick;
    logic [5:0] full_minute;
    logic       full_halt = 1'b0;
    logic [4:0] full_mag  = 5'd1;
    logic       full_pos  = 1'b0;

    int checks = 0;
    int fails  = 0;
    int gap_mode = 0;
    int en_cnt = 0;
    bit model_live = 1'b0;
    int m_pc = 0, m_sec = 0, m_min = 0;
    bit exp_tick = 1'b0;

    always #5 clk = ~clk;

    osc_cal_divider #(
        .PRE_DIV(PRE), .SUB_STEPS(SUB), .SEC_PER_MIN(SPM), .MIN_PER_CYCLE(MPC), .MAG_W(5)
    ) u_osc_cal_divider (
        .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .halt(halt),
        .cal_mag(cal_mag), .cal_pos(cal_pos),
        .sec_tick(sec_tick), .minute_idx(minute_idx)
    );

    osc_cal_divider u_osc_cal_divider_full (
        .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .halt(full_halt),
        .cal_mag(full_mag), .cal_pos(full_pos),
        .sec_tick(full_tick), .minute_idx(full_minute)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Enable pattern: every cycle, or one cycle in three.
    initial begin
        int ph = 0;
        forever begin
            @(negedge clk);
            ph++;
            osc_en = (gap_mode == 0) ? 1'b1 : ((ph % 3) == 0);
        end
    end

    // Behavioural reference: one flat enable count per second.
    always @(posedge clk) begin
        int tgt;
        model_live <= 1'b1;
        if (!rst_n) begin
            m_pc = 0; m_sec = 0; m_min = 0; exp_tick = 1'b0;
        end else begin
            exp_tick = 1'b0;
            if (halt) begin
                m_pc = 0;
            end else if (osc_en) begin
                m_pc++;
                tgt = NOM;
                if (cal_mag != 0 && m_sec == 0 && m_min < 2 * cal_mag)
                    tgt = cal_pos ? NOM - 2 * PRE : NOM + PRE;
                if (m_pc == tgt) begin
                    exp_tick = 1'b1;
                    m_pc = 0;
                    m_sec++;
                    if (m_sec == SPM) begin
                        m_sec = 0;
                        m_min = (m_min + 1) % MPC;
                    end
                end
            end
        end
        // Enables seen by the bench since the last observed tick.
        if (!rst_n || halt || sec_tick) en_cnt = 0;
        if (rst_n && !halt && osc_en) en_cnt++;
    end

    // Compare with the reference away from the clock edge.
    always @(negedge clk) begin
        if (model_live) begin
            check(sec_tick === exp_tick, "R8 tick timing", int'(sec_tick), int'(exp_tick));
            check(minute_idx === 6'(m_min), "R6 minute index", int'(minute_idx), m_min);
        end
    end

    task automatic wait_tick(output int per);
        do @(negedge clk); while (sec_tick !== 1'b1);
        per = en_cnt;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int per, mn, cnt, exp;
        rst_n = 1'b0; halt = 1'b0; cal_mag = 5'd0; cal_pos = 1'b1;
        repeat (3) @(negedge clk);
        check(sec_tick == 1'b0, "R1 tick in reset", int'(sec_tick), 0);
        check(minute_idx == 6'd0, "R1 minute in reset", int'(minute_idx), 0);
        rst_n = 1'b1;

        // R2: zero magnitude, sign set, second 0 of minute 0.
        wait_tick(per);
        check(per == NOM, "R2 mag0 sign1", per, NOM);

        // R7: halt mid-second, then a full second after release.
        repeat (10) @(negedge clk);
        halt = 1'b1; cal_pos = 1'b0;
        mn = int'(minute_idx);
        cnt = 0;
        repeat (40) begin
            @(negedge clk);
            if (sec_tick) cnt++;
        end
        check(cnt == 0, "R7 no tick while halted", cnt, 0);
        check(int'(minute_idx) == mn, "R7 minute held", int'(minute_idx), mn);
        halt = 1'b0;
        wait_tick(per);
        check(per == NOM, "R7 full second after halt", per, NOM);

        // R3 and R5: magnitude 1, slow down, three minutes.
        rst_n = 1'b0; cal_mag = 5'd1; cal_pos = 1'b0;
        do_reset();
        for (int s = 0; s < 3 * SPM; s++) begin
            wait_tick(per);
            exp = ((s % SPM) == 0 && (s / SPM) < 2) ? NOM + PRE : NOM;
            check(per == exp, (exp != NOM) ? "R3 lengthened second" : "R5 untouched second", per, exp);
            if (s == SPM - 1)
                check(minute_idx == 6'd1, "R6 minute advance", int'(minute_idx), 1);
        end

        // R4: magnitude 1, speed up.
        cal_pos = 1'b1;
        do_reset();
        wait_tick(per);
        check(per == NOM - 2 * PRE, "R4 shortened second", per, NOM - 2 * PRE);
        wait_tick(per);
        check(per == NOM, "R5 second 1 untouched", per, NOM);

        // R5, R6, R9: magnitude 31, sparse enables, full frame and wrap.
        cal_mag = 5'd31; gap_mode = 1;
        do_reset();
        for (int s = 0; s <= MPC * SPM; s++) begin
            wait_tick(per);
            exp = ((s % SPM) == 0 && ((s / SPM) % MPC) < 62) ? NOM - 2 * PRE : NOM;
            check(per == exp, "R5 R9 window with sparse enables", per, exp);
            if (s == MPC * SPM - 1)
                check(minute_idx == 6'd0, "R6 frame wrap", int'(minute_idx), 0);
        end

        // R3 at default parameters: 32,896 then 32,768 enables.
        gap_mode = 0;
        do_reset();
        cnt = 0;
        do begin @(negedge clk); cnt++; end while (full_tick !== 1'b1);
        check(cnt == 32896, "R3 default lengthened second", cnt, 32896);
        cnt = 0;
        do begin @(negedge clk); cnt++; end while (full_tick !== 1'b1);
        check(cnt == 32768, "R2 default nominal second", cnt, 32768);

        finish_run();
    end
endmodule